// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel Trim Code Bank

This block is the digital front end of an eight-channel, 8-bit trim converter. A host writes one channel at a time over a three-wire serial port: a serial clock, a data line and an active-low select. While select is low, every rising serial-clock edge shifts one data bit into an 11-bit frame register. When select returns high, the frame is decoded. Its three leading bits name the channel and its eight trailing bits become that channel's output code.

All eight codes are presented in parallel to the converters on one 64-bit bus. Reset sets every code to mid-scale. The serial pins are sampled by the system clock, and edges are found by comparing each sample with the one before. A one-cycle load strobe and a channel index accompany every register write. A registered power-down flag passes the shutdown request on to the analog section and leaves the stored codes alone.

Top module: `trim_dac_regs`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, every code byte becomes 8'h80, `load_stb` becomes 0 and the frame state is emptied.
- R2: Serial-clock rising edges that occur while `cs_n` is high shift in no bits and change no code.
- R3: A frame is sent most significant bit first: address bits A2, A1, A0, then data bits D7 to D0. When `cs_n` rises after a full frame, the data byte is stored for channel A (0 to 7), which drives `codes[8*A+7:8*A]`.
- R4: If more than 11 bits arrive in one select-low window, only the last 11 bits before `cs_n` rises are used.
- R5: If `cs_n` rises after fewer than 11 bits, no code is written and no strobe is given.
- R6: A write raises `load_stb` for exactly one cycle, with `load_ch` set to the written channel. The strobe is seen after the second `clk` rising edge that follows the rise of `cs_n`.
- R7: A write changes only the addressed channel's byte. All other bytes keep their values.
- R8: `pwr_down` equals the inverse of `shdn_n` one clock later. Shutdown leaves the stored codes unchanged, and frames are still accepted during shutdown.
- R9: A falling edge of `cs_n` discards any bits left from an earlier window. A frame split across two select-low windows writes nothing.
- R10: A reset applied after codes have been written returns every channel to 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset; presets codes to mid-scale |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, sent most significant bit first |
| cs_n | input | 1 | Active-low select; its rising edge commits the frame |
| shdn_n | input | 1 | Active-low shutdown request for the analog section |
| codes | output | 64 | Eight 8-bit codes; channel 0 occupies bits 7:0 |
| load_stb | output | 1 | One-cycle pulse on each code write |
| load_ch | output | 3 | Channel written when `load_stb` is high |
| pwr_down | output | 1 | Registered power-down flag for the converters |

## Verification
Exact 11-bit frames are sent to channels at both ends and in the middle of the address range. Any mix-up of address order, byte lanes or bit order shows up as a byte in the wrong place or with the wrong value. Over-long frames with leading junk show whether the newest bits are the ones kept. Short frames, and frames split by a select pulse, show whether the bit count gates the write and is cleared when select falls. Clock pulses sent while select is high, a write made during shutdown, and a reset after writes separate the ignore, retain and preset behaviours from the normal load path.

// File: rtl/trim_pkg.sv
// Shared sizing constants for the serial trim code bank.
// Assumes every channel code has the same width and the frame is address then data.
package trim_pkg;
    parameter int CH_N     = 8;
    parameter int CODE_W   = 8;
    parameter int ADDR_W   = $clog2(CH_N);
    parameter int FRAME_W  = ADDR_W + CODE_W;
    parameter int CNT_W    = $clog2(FRAME_W + 1);
    parameter int BUS_W    = CH_N * CODE_W;
    parameter logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
endpackage

// File: rtl/trim_serial_rx.sv
// Serial frame receiver: samples the three serial pins with the system clock,
// shifts bits on serial-clock rises while select is low, and emits a one-cycle
// write request on a select rise that follows a complete frame.
// Assumes the serial pins change slowly compared with clk (at least two clk per level).
module trim_serial_rx
    import trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              cs_n_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [CODE_W-1:0] wr_data_o
);
    logic               sclk_q, sdi_q, cs_q;
    logic               sclk_d, cs_d;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               sclk_rise, cs_rise, cs_fall, frame_full;

    // Sample the pins and keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sdi_q  <= 1'b0;
            cs_q   <= 1'b1;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            sdi_q  <= sdi_i;
            cs_q   <= cs_n_i;
            sclk_d <= sclk_q;
            cs_d   <= cs_q;
        end
    end

    // Decode pin edges from the two sample stages.
    always_comb begin
        sclk_rise  = sclk_q && !sclk_d && !cs_q;
        cs_rise    = cs_q && !cs_d;
        cs_fall    = !cs_q && cs_d;
        frame_full = (bit_cnt == CNT_W'(FRAME_W));
    end

    // Shift register and saturating bit counter, emptied when select falls.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], sdi_q};
            if (!frame_full) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Present the decoded write request.
    always_comb begin
        wr_en_o   = cs_rise && frame_full;
        wr_addr_o = shreg[FRAME_W-1:CODE_W];
        wr_data_o = shreg[CODE_W-1:0];
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q && cs_d) |=> $stable(shreg));
endmodule

// File: rtl/trim_code_bank.sv
// Bank of per-channel code registers preset to mid-scale, plus the write strobe.
// Assumes at most one write request per cycle.
module trim_code_bank
    import trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CODE_W-1:0] wr_data_i,
    output logic [BUS_W-1:0]  codes_o,
    output logic              load_stb_o,
    output logic [ADDR_W-1:0] load_ch_o
);
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        logic [CODE_W-1:0] code_q;
        // Hold one channel code; load it when the address matches.
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q <= MID_CODE;
            else if (wr_en_i && wr_addr_i == ADDR_W'(ch))
                code_q <= wr_data_i;
        end
        assign codes_o[ch*CODE_W +: CODE_W] = code_q;
    end

    // Register the strobe and channel index of each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_stb_o <= 1'b0;
            load_ch_o  <= '0;
        end else begin
            load_stb_o <= wr_en_i;
            if (wr_en_i) load_ch_o <= wr_addr_i;
        end
    end

    // R7
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(codes_o));
endmodule

// File: rtl/trim_dac_regs.sv
// Top of the serial trim code bank: receiver, register bank and power-down flag.
// Assumes all inputs are in the clk domain or slow enough to be sampled directly.
module trim_dac_regs
    import trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              shdn_n,
    output logic [BUS_W-1:0]  codes,
    output logic              load_stb,
    output logic [ADDR_W-1:0] load_ch,
    output logic              pwr_down
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] wr_data;

    trim_serial_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .sdi_i     (sdi),
        .cs_n_i    (cs_n),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    trim_code_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .codes_o    (codes),
        .load_stb_o (load_stb),
        .load_ch_o  (load_ch)
    );

    // Register the power-down request for the analog section.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_down <= 1'b0;
        else        pwr_down <= !shdn_n;
    end

    // R6
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R1
    mid_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (codes == {CH_N{MID_CODE}}));
endmodule

// File: tb/trim_dac_regs_test.sv
module trim_dac_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, shdn_n = 1'b1;
    logic [63:0] codes;
    logic        load_stb;
    logic [2:0]  load_ch;
    logic        pwr_down;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct packed { logic [2:0] ch; logic [7:0] d; } wr_t;
    wr_t         exp_q[$];
    logic [63:0] model = {8{8'h80}};

    trim_dac_regs uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .shdn_n(shdn_n), .codes(codes), .load_stb(load_stb),
        .load_ch(load_ch), .pwr_down(pwr_down)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Send the low n bits of v, most significant first, on the serial port.
    task automatic send_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            waitn(2);
            sclk = 1'b1;
            waitn(2);
            sclk = 1'b0;
        end
    endtask

    // One select-low window; when wr is set, push the expected write and time the strobe.
    task automatic frame(input int n, input logic [31:0] v, input bit wr, input string req);
        cs_n = 1'b0;
        waitn(3);
        send_bits(n, v);
        waitn(2);
        if (wr) exp_q.push_back(wr_t'(v[10:0]));
        cs_n = 1'b1;
        waitn(2);
        if (wr) begin
            check(load_stb === 1'b1, {req, " R6 strobe latency"}, 64'(load_stb), 64'd1);
            waitn(1);
            check(load_stb === 1'b0, {req, " R6 strobe width"}, 64'(load_stb), 64'd0);
        end else begin
            waitn(1);
        end
        waitn(3);
    endtask

    // Scoreboard monitor: every strobe must match the next expected write.
    always @(negedge clk) begin
        if (rst_n && load_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R9 unexpected write", 64'(load_ch), 64'd0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                model[e.ch*8 +: 8] = e.d;
                check(load_ch === e.ch, "R6 channel index", 64'(load_ch), 64'(e.ch));
                check(codes === model, "R3/R7 code bus", codes, model);
            end
        end
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        waitn(3);
        // R1 reset state
        check(codes === {8{8'h80}}, "R1 mid-scale preset", codes, {8{8'h80}});
        check(load_stb === 1'b0, "R1 no strobe in reset", 64'(load_stb), 64'd0);
        rst_n = 1'b1;
        waitn(2);
        check(pwr_down === 1'b0, "R8 flag idle", 64'(pwr_down), 64'd0);

        // R3 exact frames to channels 0, 7, 3
        frame(11, {21'd0, 3'd0, 8'h3C}, 1'b1, "R3 ch0");
        frame(11, {21'd0, 3'd7, 8'hA5}, 1'b1, "R3 ch7");
        frame(11, {21'd0, 3'd3, 8'h5A}, 1'b1, "R3 ch3");
        check(codes[7:0] === 8'h3C, "R3 ch0 lane", 64'(codes[7:0]), 64'h3C);
        check(codes[63:56] === 8'hA5, "R3 ch7 lane", 64'(codes[63:56]), 64'hA5);

        // R2 serial clocks while select is high
        send_bits(11, {21'd0, 3'd1, 8'hFF});
        waitn(4);
        check(codes === model, "R2 ignored clocks", codes, model);
        check(load_stb === 1'b0, "R2 no strobe", 64'(load_stb), 64'd0);

        // R4 over-long frame: four junk bits then channel 5 data 0x77
        frame(15, {17'd0, 4'b1011, 3'd5, 8'h77}, 1'b1, "R4 long");
        check(codes[47:40] === 8'h77, "R4 last bits kept", 64'(codes[47:40]), 64'h77);

        // R5 short frame of 10 bits
        frame(10, {22'd0, 2'd2, 8'h11}, 1'b0, "R5 short");
        check(codes === model, "R5 short frame no write", codes, model);

        // R9 frame split across two windows
        frame(6, {26'd0, 3'd6, 3'b101}, 1'b0, "R9 part1");
        frame(5, {27'd0, 5'b10101}, 1'b0, "R9 part2");
        check(codes === model, "R9 no carry-over", codes, model);

        // R8 shutdown retains codes and still accepts writes
        shdn_n = 1'b0;
        waitn(1);
        check(pwr_down === 1'b1, "R8 flag set", 64'(pwr_down), 64'd1);
        check(codes === model, "R8 codes retained", codes, model);
        frame(11, {21'd0, 3'd2, 8'hC3}, 1'b1, "R8 write in shutdown");
        shdn_n = 1'b1;
        waitn(1);
        check(pwr_down === 1'b0, "R8 flag clear", 64'(pwr_down), 64'd0);
        check(codes === model, "R8 codes after release", codes, model);

        // R10 reset after writes
        rst_n = 1'b0;
        waitn(2);
        rst_n = 1'b1;
        model = {8{8'h80}};
        waitn(1);
        check(codes === {8{8'h80}}, "R10 reset to mid-scale", codes, {8{8'h80}});
        frame(11, {21'd0, 3'd4, 8'h00}, 1'b1, "R3 ch4 after reset");

        check(exp_q.size() == 0, "R6 all writes seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule